// File: doc/BRIEF.md
# Automatic Low-Power Entry Timer

This block decides when a storage controller drops into its low-power state. A two-bit mode field selects one of four behaviours. The block can stay awake always. It can enter low power a fixed delay after the head-unload timer runs out. It can enter low power at once when the field is written. The fourth code is reserved and behaves like the first. The delay is counted in ticks of an external 1 ms time base. It is `BASE_TICKS` ticks (512 by default) at the fast data rates and twice that at the slowest rate.

Any drive or host activity pulses the wake input. A wake stops a countdown that is still running and takes the block out of low power. A manual entry happens only on a write of the mode field. After the block wakes from a manual entry, it stays awake until the field is written again. A new head-unload expiry always restarts the countdown from zero, and the data-rate code is latched at that moment.

Top module: `lpt_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `low_power_o` is 0 and no countdown runs.
- R2: With mode code 2'b00, head-unload expiries and ticks never raise `low_power_o`.
- R3: Mode code 2'b11 behaves exactly like 2'b00.
- R4: With mode code 2'b01 and a rate code other than 2'b10, `low_power_o` rises in the cycle after the `BASE_TICKS`-th tick that follows an expiry. After one tick fewer it is still 0.
- R5: With mode code 2'b01 and rate code 2'b10 (the 250 kb/s rate), the delay is 2×`BASE_TICKS` ticks.
- R6: The rate code is latched when the countdown starts. Changing it during the countdown does not change the delay.
- R7: An expiry that arrives during a countdown restarts the count from zero.
- R8: A wake pulse makes `low_power_o` 0 in the next cycle and stops any running countdown, so later ticks cause no entry.
- R9: A write of mode code 2'b10 raises `low_power_o` in the next cycle, and it stays high until a wake.
- R10: After a wake from manual entry, the block does not re-enter low power while the field stays 2'b10 unwritten. A fresh write of 2'b10 re-enters.
- R11: Code 2'b00 or 2'b11 on the mode field clears `low_power_o` and stops a running countdown.
- R12: Ticks that come with no preceding expiry do nothing. A wake in the same cycle as a manual write wins, so the block stays awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Low-power mode field (level) |
| mode_wr_i | input | 1 | One-cycle strobe: the mode field was written |
| unload_exp_i | input | 1 | One-cycle pulse: head-unload timer expired |
| rate_i | input | 2 | Data-rate code; 2'b10 selects the doubled delay |
| wake_i | input | 1 | One-cycle pulse: host or drive activity |
| tick_i | input | 1 | One-cycle 1 ms time-base strike |
| low_power_o | output | 1 | High while the controller is in low power |

## Verification
The bench probes the delay one tick short of the limit and again at the limit, at both rates. An off-by-one counter would enter early or late, and a missing doubling would enter at half time at 250 kb/s. It changes the rate in the middle of a countdown, which catches a design that reads the rate live instead of latching it. It sends a second expiry into a running countdown, which exposes a design that does not restart the count. It also covers a wake followed by more ticks, repeated manual entry with no fresh write, a mode change to off during a countdown, and a wake that coincides with a manual write. Each of these exposes a design that keeps stale state or that orders the priorities wrongly.

// File: rtl/lpt_pkg.sv
// Shared definitions for the low-power entry timer.
// Assumes: two-bit mode field and two-bit rate code.
package lpt_pkg;

    typedef enum logic [1:0] {
        LPM_OFF  = 2'b00,
        LPM_AUTO = 2'b01,
        LPM_NOW  = 2'b10,
        LPM_RSVD = 2'b11
    } lp_mode_e;

    // Rate code that selects the doubled delay (250 kb/s)
    localparam logic [1:0] RATE_SLOW_CODE = 2'b10;

    // True for the codes that keep the block awake
    function automatic logic mode_is_off(input logic [1:0] m);
        return (m == LPM_OFF) || (m == LPM_RSVD);
    endfunction

endpackage

// File: rtl/lpt_mode_dec.sv
// Mode decoder: turns the mode field and its write strobe into the
// enables that the countdown and the state register use.
// Assumes: mode_wr_i is a one-cycle strobe that comes with the new value.
module lpt_mode_dec
    import lpt_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       mode_wr_i,
    output logic       auto_en_o,
    output logic       off_o,
    output logic       manual_req_o
);

    // Purpose: decode the mode level and detect a manual-entry write
    always_comb begin
        auto_en_o    = (mode_i == LPM_AUTO);
        off_o        = mode_is_off(mode_i);
        manual_req_o = mode_wr_i && (mode_i == LPM_NOW);
    end

endmodule

// File: rtl/lpt_delay.sv
// Post-unload countdown: loads a target when it starts, counts tick_i
// strikes, and pulses expire_o on the strike that completes the delay.
// Assumes: priority is cancel, then start, then tick. A tick that comes
// in the start cycle is not counted.
module lpt_delay
    import lpt_pkg::*;
#(
    parameter int BASE_TICKS = 512,
    localparam int CW        = $clog2(2 * BASE_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cancel_i,
    input  logic       tick_i,
    input  logic [1:0] rate_i,
    output logic       expire_o
);

    localparam logic [CW-1:0] T_FAST = CW'(BASE_TICKS);
    localparam logic [CW-1:0] T_SLOW = CW'(2 * BASE_TICKS);

    logic          running_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target_q;
    logic          last_tick;

    // Purpose: detect that the current strike is the final one
    always_comb begin
        last_tick = running_q && tick_i && (cnt_q == target_q - CW'(1));
        expire_o  = last_tick && !cancel_i && !start_i;
    end

    // Purpose: countdown state, with the rate latched at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            target_q  <= T_FAST;
        end else if (cancel_i) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (start_i) begin
            running_q <= 1'b1;
            cnt_q     <= '0;
            target_q  <= (rate_i == RATE_SLOW_CODE) ? T_SLOW : T_FAST;
        end else if (running_q && tick_i) begin
            if (last_tick) begin
                running_q <= 1'b0;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/lpt_state.sv
// Low-power state flag: set by a manual request or by the end of the
// countdown, cleared by a wake or an off mode.
// Assumes: clearing wins over setting in the same cycle.
module lpt_state (
    input  logic clk,
    input  logic rst_n,
    input  logic off_i,
    input  logic wake_i,
    input  logic manual_req_i,
    input  logic expire_i,
    output logic low_power_o
);

    logic lp_q;

    // Purpose: hold the low-power flag, with clear taking priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            lp_q <= 1'b0;
        else if (off_i || wake_i)
            lp_q <= 1'b0;
        else if (manual_req_i || expire_i)
            lp_q <= 1'b1;
    end

    assign low_power_o = lp_q;

endmodule

// File: rtl/lpt_ctrl.sv
// Top level of the automatic low-power entry timer. It joins the mode
// decoder, the post-unload countdown and the state flag.
// Assumes: all pulse inputs last one cycle and are synchronous to clk.
module lpt_ctrl #(
    parameter int BASE_TICKS = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       mode_wr_i,
    input  logic       unload_exp_i,
    input  logic [1:0] rate_i,
    input  logic       wake_i,
    input  logic       tick_i,
    output logic       low_power_o
);

    logic auto_en;
    logic off;
    logic manual_req;
    logic expire;
    logic cd_start;
    logic cd_cancel;

    lpt_mode_dec u_dec (
        .mode_i       (mode_i),
        .mode_wr_i    (mode_wr_i),
        .auto_en_o    (auto_en),
        .off_o        (off),
        .manual_req_o (manual_req)
    );

    // Purpose: a countdown starts only in auto mode while awake; a wake
    // or leaving auto mode stops it
    always_comb begin
        cd_cancel = wake_i || !auto_en;
        cd_start  = unload_exp_i && auto_en && !low_power_o;
    end

    lpt_delay #(.BASE_TICKS(BASE_TICKS)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (cd_start),
        .cancel_i (cd_cancel),
        .tick_i   (tick_i),
        .rate_i   (rate_i),
        .expire_o (expire)
    );

    lpt_state u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .off_i        (off),
        .wake_i       (wake_i),
        .manual_req_i (manual_req),
        .expire_i     (expire),
        .low_power_o  (low_power_o)
    );

endmodule

// File: rtl/lpt_ctrl_chk.sv
// Port-level checker for lpt_ctrl, attached to it with bind.
module lpt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       mode_wr_i,
    input logic       wake_i,
    input logic       tick_i,
    input logic       low_power_o
);

    AST_WAKE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> !low_power_o);  // R8

    AST_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 || mode_i == 2'b11) |=> !low_power_o);  // R11

    AST_MANUAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && mode_i == 2'b10 && !wake_i) |=> low_power_o);  // R9

    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_power_o) |->
            $past((mode_wr_i && mode_i == 2'b10) || (tick_i && mode_i == 2'b01)));  // R12

    AST_HOLD_LOW_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power_o && !wake_i && !mode_wr_i && (mode_i == 2'b01 || mode_i == 2'b10))
            |=> low_power_o);  // R10

endmodule

bind lpt_ctrl lpt_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .mode_wr_i   (mode_wr_i),
    .wake_i      (wake_i),
    .tick_i      (tick_i),
    .low_power_o (low_power_o)
);

// File: tb/lpt_ctrl_tb.sv
module lpt_ctrl_tb;

    localparam int B = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       mode_wr_i = 1'b0;
    logic       unload_exp_i = 1'b0;
    logic [1:0] rate_i = 2'b00;
    logic       wake_i = 1'b0;
    logic       tick_i = 1'b0;
    logic       low_power_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lpt_ctrl #(.BASE_TICKS(B)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .mode_wr_i    (mode_wr_i),
        .unload_exp_i (unload_exp_i),
        .rate_i       (rate_i),
        .wake_i       (wake_i),
        .tick_i       (tick_i),
        .low_power_o  (low_power_o)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       wr;
        logic       unl;
        logic [1:0] rate;
        logic       wake;
        logic [7:0] nt;
        logic       exp_lp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VT [NV] = '{
        '{2'b01, 1'b1, 1'b1, 2'b00, 1'b0, 8'd15, 1'b0, 4'd4},   // R4 one short
        '{2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 8'd1,  1'b1, 4'd4},   // R4 at limit
        '{2'b01, 1'b0, 1'b0, 2'b00, 1'b1, 8'd0,  1'b0, 4'd8},
        '{2'b01, 1'b0, 1'b1, 2'b10, 1'b0, 8'd31, 1'b0, 4'd5},   // R5 one short
        '{2'b01, 1'b0, 1'b0, 2'b10, 1'b0, 8'd1,  1'b1, 4'd5},   // R5 at limit
        '{2'b01, 1'b0, 1'b0, 2'b10, 1'b1, 8'd0,  1'b0, 4'd8},
        '{2'b01, 1'b0, 1'b1, 2'b10, 1'b0, 8'd20, 1'b0, 4'd6},
        '{2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 8'd11, 1'b0, 4'd6},   // R6 rate change ignored
        '{2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 8'd1,  1'b1, 4'd6},
        '{2'b01, 1'b0, 1'b0, 2'b00, 1'b1, 8'd0,  1'b0, 4'd8},
        '{2'b01, 1'b0, 1'b1, 2'b00, 1'b0, 8'd10, 1'b0, 4'd7},
        '{2'b01, 1'b0, 1'b1, 2'b00, 1'b0, 8'd15, 1'b0, 4'd7},   // R7 restart
        '{2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 8'd1,  1'b1, 4'd7},
        '{2'b01, 1'b0, 1'b0, 2'b00, 1'b1, 8'd0,  1'b0, 4'd8},
        '{2'b01, 1'b0, 1'b1, 2'b00, 1'b0, 8'd8,  1'b0, 4'd8},
        '{2'b01, 1'b0, 1'b0, 2'b00, 1'b1, 8'd20, 1'b0, 4'd8},   // R8 cancel
        '{2'b00, 1'b1, 1'b1, 2'b00, 1'b0, 8'd40, 1'b0, 4'd2},   // R2
        '{2'b11, 1'b1, 1'b1, 2'b00, 1'b0, 8'd40, 1'b0, 4'd3},   // R3
        '{2'b10, 1'b1, 1'b0, 2'b00, 1'b0, 8'd0,  1'b1, 4'd9},   // R9
        '{2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 8'd0,  1'b0, 4'd10},
        '{2'b10, 1'b0, 1'b1, 2'b00, 1'b0, 8'd40, 1'b0, 4'd10},  // R10 no re-entry
        '{2'b10, 1'b1, 1'b0, 2'b00, 1'b0, 8'd0,  1'b1, 4'd10},  // R10 re-entry
        '{2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 8'd0,  1'b0, 4'd11},  // R11 clear
        '{2'b01, 1'b1, 1'b0, 2'b00, 1'b0, 8'd40, 1'b0, 4'd12},  // R12 ticks only
        '{2'b01, 1'b1, 1'b1, 2'b00, 1'b0, 8'd8,  1'b0, 4'd11},
        '{2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 8'd0,  1'b0, 4'd11},
        '{2'b01, 1'b1, 1'b0, 2'b00, 1'b0, 8'd20, 1'b0, 4'd11}   // R11 cancel
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: low_power_o=%b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            cyc();
            tick_i = 1'b0;
            cyc();
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        cyc(); cyc();
        check("R1 in reset", low_power_o, 1'b0);
        rst_n = 1'b1;
        cyc();
        check("R1 after reset", low_power_o, 1'b0);

        for (int v = 0; v < NV; v++) begin
            mode_i       = VT[v].mode;
            mode_wr_i    = VT[v].wr;
            unload_exp_i = VT[v].unl;
            rate_i       = VT[v].rate;
            wake_i       = VT[v].wake;
            cyc();
            mode_wr_i    = 1'b0;
            unload_exp_i = 1'b0;
            wake_i       = 1'b0;
            ticks(int'(VT[v].nt));
            cyc();
            check($sformatf("R%0d vector %0d", VT[v].req, v), low_power_o, VT[v].exp_lp);
        end

        // R9: entry is visible in the very next cycle
        mode_i = 2'b10; mode_wr_i = 1'b1;
        cyc();
        mode_wr_i = 1'b0;
        check("R9 next cycle", low_power_o, 1'b1);

        // R1: reset while in low power clears it
        rst_n = 1'b0;
        cyc();
        check("R1 mid-run reset", low_power_o, 1'b0);
        rst_n = 1'b1;
        cyc();

        // R12: wake in the same cycle as a manual write wins
        mode_i = 2'b10; mode_wr_i = 1'b1; wake_i = 1'b1;
        cyc();
        mode_wr_i = 1'b0; wake_i = 1'b0;
        cyc();
        check("R12 wake beats write", low_power_o, 1'b0);

        // R8: wake in the same cycle as the final tick stops entry
        mode_i = 2'b01; mode_wr_i = 1'b1; unload_exp_i = 1'b1; rate_i = 2'b00;
        cyc();
        mode_wr_i = 1'b0; unload_exp_i = 1'b0;
        ticks(B - 1);
        tick_i = 1'b1; wake_i = 1'b1;
        cyc();
        tick_i = 1'b0; wake_i = 1'b0;
        cyc();
        check("R8 wake on last tick", low_power_o, 1'b0);

        finish_run();
    end

endmodule